// File: doc/BRIEF.md
# Register-Mapped Interrupt Controller

The block collects a parameterised number of interrupt inputs (up to 32) and drives one request line toward a processor. Each input is fixed at elaboration as edge-sensitive or level-sensitive by a kind mask, where a 1 selects edge detection. Detected requests latch into a status register. The request reaches the processor only when its enable bit is set and both bits of a two-bit master control register are set.

Software talks to the block through a single-cycle 32-bit register port. The port has a 3-bit word index, a write strobe, write data, and combinational read data. Enables can be loaded directly, or changed bit by bit through write-one-to-set and write-one-to-clear aliases. Latched requests are cleared through a write-one acknowledge register. A vector register names the lowest-numbered input that is both latched and enabled, so an interrupt handler can dispatch without scanning.

All inputs are assumed synchronous to `clk`.

Top module: `irq_ctl`

## Requirements
- R1: The word index selects the register: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master control. After reset, status, enable and master control read 0, vector reads 0xFFFFFFFF and `irq_out` is low.
- R2: An edge-kind input latches its status bit when the line is sampled high at a clock edge after being sampled low at the previous edge. A line that stays high does not latch again after an acknowledge.
- R3: A level-kind input latches its status bit at every clock edge where its line is high. An acknowledge while the line is still high leaves the bit set.
- R4: A write of ones to the acknowledge register clears those status bits. Bits written 0 are untouched, and writing all ones clears every request whose input is not re-latching. A latch condition in the same cycle as an acknowledge wins.
- R5: A write to the enable register loads its low N bits. Writing 0 disables every input.
- R6: Writing the set-enable register sets each enable bit written as 1 and leaves the other enable bits unchanged.
- R7: Writing the clear-enable register clears each enable bit written as 1 and leaves the other enable bits unchanged.
- R8: The pending register reads status AND enable.
- R9: The vector register reads the index of the lowest-numbered pending bit. With no pending bit it reads 0xFFFFFFFF.
- R10: Master control bit 0 is the master enable and bit 1 is the hardware request enable. `irq_out` is high exactly when both bits are 1 and some bit is pending.
- R11: Writes to status, pending and vector have no effect. Acknowledge, set-enable and clear-enable read as 0. Register bits above N, and master control bits above 1, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src | input | N_SRC | Interrupt input lines |
| addr | input | 3 | Register word index |
| wr_en | input | 1 | Write strobe, one register write per cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the register at `addr`, combinational |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench uses eight inputs, with the upper four edge-kind and the lower four level-kind. It sweeps all 256 status patterns against a varied enable word, which exposes a priority encoder that picks the highest bit or fails to return all ones when nothing is pending. It holds a line high across an acknowledge: a design that treats edge inputs as level would re-latch them, and one that treats level inputs as edge would drop a live request. It also walks the aliases with mixed ones and zeros, which catches aliases that overwrite the enable register instead of modifying it, and it walks all four master control values, which catches an output gated by only one of the two bits.

// File: rtl/irq_ctl.sv
module irq_ctl #(
  parameter int N_SRC = 32,
  parameter logic [N_SRC-1:0] EDGE_KIND = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src,
  input  logic [2:0]       addr,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  output logic             irq_out
);
  localparam logic [2:0] A_STAT = 3'd0, A_PEND = 3'd1, A_EN = 3'd2, A_ACK = 3'd3,
                         A_SET = 3'd4, A_CLR = 3'd5, A_VEC = 3'd6, A_MC = 3'd7;

  logic [N_SRC-1:0] stat, en, src_q, hit, pend, wbits;
  logic [1:0]       mc;
  logic [31:0]      vec;

  assign wbits = wr_data[N_SRC-1:0];
  assign hit   = (EDGE_KIND & src & ~src_q) | (~EDGE_KIND & src);
  assign pend  = stat & en;
  assign irq_out = mc[0] & mc[1] & (|pend);

  always_comb begin
    vec = '1;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (pend[i]) vec = 32'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat  <= '0;
      en    <= '0;
      src_q <= '0;
      mc    <= '0;
    end else begin
      src_q <= src;
      if (wr_en && addr == A_ACK) stat <= (stat & ~wbits) | hit;
      else                        stat <= stat | hit;
      if (wr_en) begin
        case (addr)
          A_EN:    en <= wbits;
          A_SET:   en <= en | wbits;
          A_CLR:   en <= en & ~wbits;
          A_MC:    mc <= wr_data[1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_STAT:  rd_data = 32'(stat);
      A_PEND:  rd_data = 32'(pend);
      A_EN:    rd_data = 32'(en);
      A_VEC:   rd_data = vec;
      A_MC:    rd_data = {30'd0, mc};
      default: rd_data = '0;
    endcase
  end

  // R6
  set_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SET) |=> ((en & $past(wbits)) == $past(wbits)));
  // R7
  clr_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR) |=> ((en & $past(wbits)) == '0));
  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ACK) |=> ((stat & $past(wbits) & ~$past(hit)) == '0));
  // R9
  vec_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend) |-> (vec < 32'(N_SRC) && pend[vec[4:0]]));
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (mc == 2'b11 && vec != '1));
  // R2
  latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((stat & $past(hit)) == $past(hit)));
endmodule

// File: tb/sim_irq_ctl.sv
module sim_irq_ctl;
  localparam int N = 8;
  localparam logic [N-1:0] KIND = 8'hF0;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [N-1:0] src = '0;
  logic [2:0] addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic irq_out;
  int checks = 0, fails = 0;

  irq_ctl #(.N_SRC(N), .EDGE_KIND(KIND)) u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic pulse(logic [N-1:0] p);
    @(negedge clk); src = p;
    @(negedge clk); src = '0;
  endtask

  function automatic logic [31:0] lowest(logic [N-1:0] p);
    for (int i = 0; i < N; i++) if (p[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset read", v, a == 6 ? 32'hFFFF_FFFF : 32'h0);
    end
    chk("R1 reset irq", 32'(irq_out), 0);

    wr(3'd7, 32'h3);
    for (int i = 0; i < N; i++) begin
      pulse(8'(1 << i));
      rd(3'd0, v); chk(KIND[i] ? "R2 edge latch" : "R3 level latch", v, 32'(1 << i));
      rd(3'd1, v); chk("R8 pending off", v, 0);
      chk("R10 irq off", 32'(irq_out), 0);
      wr(3'd4, 32'(1 << i));
      rd(3'd1, v); chk("R8 pending on", v, 32'(1 << i));
      rd(3'd6, v); chk("R9 vector", v, 32'(i));
      chk("R10 irq on", 32'(irq_out), 1);
      wr(3'd3, 32'(1 << i));
      rd(3'd0, v); chk("R4 ack clears", v, 0);
      wr(3'd2, 32'h0);
      rd(3'd2, v); chk("R5 enable zero", v, 0);
    end

    // R2 edge line held high: ack clears, no relatch
    @(negedge clk); src = 8'h10; @(negedge clk);
    wr(3'd3, 32'h10);
    rd(3'd0, v); chk("R2 held edge", v, 0);
    // R3 level line held high: ack leaves set
    src = 8'h12; @(negedge clk);
    wr(3'd3, 32'h02);
    rd(3'd0, v); chk("R3 held level", v, 32'h02);
    @(negedge clk); src = '0; @(negedge clk);
    wr(3'd3, 32'h0000_0004);
    rd(3'd0, v); chk("R4 zero bits kept", v, 32'h02);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R4 ack all", v, 0);

    // R6 R7 aliases
    wr(3'd2, 32'h5A);
    wr(3'd4, 32'h81);
    rd(3'd2, v); chk("R6 set alias", v, 32'hDB);
    wr(3'd5, 32'h0A);
    rd(3'd2, v); chk("R7 clear alias", v, 32'hD1);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R11 upper enable bits", v, 32'hFF);

    // R11 read-only / write-only
    pulse(8'h21);
    wr(3'd0, 32'h0); wr(3'd1, 32'h0); wr(3'd6, 32'h0);
    rd(3'd0, v); chk("R11 status ro", v, 32'h21);
    rd(3'd6, v); chk("R11 vector ro", v, 0);
    rd(3'd3, v); chk("R11 ack reads 0", v, 0);
    rd(3'd4, v); chk("R11 set reads 0", v, 0);
    rd(3'd5, v); chk("R11 clr reads 0", v, 0);

    // R10 master control sweep
    for (int m = 0; m < 4; m++) begin
      wr(3'd7, 32'hFFFF_FFFC | 32'(m));
      rd(3'd7, v); chk("R11 master readback", v, 32'(m));
      chk("R10 master gate", 32'(irq_out), 32'(m == 3));
    end

    // R8 R9 pattern sweep
    for (int p = 0; p < 256; p++) begin
      logic [N-1:0] e;
      e = 8'((p * 37 + 11) & 255);
      wr(3'd3, 32'hFFFF_FFFF);
      pulse(8'(p));
      wr(3'd2, 32'(e));
      rd(3'd1, v); chk("R8 sweep pending", v, 32'(8'(p) & e));
      rd(3'd6, v); chk("R9 sweep vector", v, lowest(8'(p) & e));
      chk("R10 sweep irq", 32'(irq_out), 32'((8'(p) & e) != 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule